// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Underflow Clock Outputs

This block is one timer channel. It holds an 8-bit count and an 8-bit reload value. While the channel runs, each pulse on the `tick` input decrements the count by one. A tick that finds the count at zero is an underflow. An underflow loads the reload value back into the count on that same tick, so the underflow period is reload+1 ticks. The tick comes from a prescaler outside the block.

Each underflow has three effects:
- It drives a pin-level output, one clock wide.
- It toggles a half-rate clock that can serve as the bit clock of a serial port.
- It sets an interrupt flag, which reaches the CPU only when the interrupt enable bit is set.

A small register port gives access to the control bits, the reload value, the live count and the interrupt controls. The interrupt controls include a 3-bit priority level, which is passed out unchanged for an arbiter outside the block. Stopping the channel freezes the count, and starting it again resumes from the frozen value. A preset command copies the reload value into the count at any time. When the clock output is disabled, the pin output is held low and the serial clock is held high.

Register map (`bus_addr`):
- 0 is control: bit 0 is run, bit 1 is preset (write-only, reads 0), bit 2 is the clock output enable.
- 1 is the reload value.
- 2 is the count. It is read-only, and writes to it are ignored.
- 3 is the interrupt register: bit 0 is the enable, bit 1 is the flag (write 1 to clear), bits 6:4 are the level.

All unlisted bits read 0.

Top module: `tick_timer`

## Requirements
- R1: After reset the run bit, clock output enable, interrupt enable, interrupt flag, level, count and reload are all 0, `pin_out` and `irq` are 0, and `ser_clk` is 1.
- R2: Control bits 0 (run) and 2 (output enable) read back as written at address 0; bit 1 and all other bits read 0.
- R3: While run is 1, each cycle with `tick` high decrements the count by one; without a tick, or with run at 0, the count holds; writes to address 2 are ignored.
- R4: Clearing run freezes the count through any number of ticks; setting run again resumes counting from the frozen value, not from the reload value.
- R5: A tick while running with the count at 0 loads the reload value into the count in that same cycle.
- R6: Writing 1 to control bit 1 loads the reload value into the count on that edge, whether running or stopped, and takes precedence over a tick in the same cycle.
- R7: With the output enable at 1, `pin_out` is high for exactly the cycle after each underflow edge; with it at 0, `pin_out` stays 0.
- R8: With the output enable at 1, `ser_clk` inverts on every underflow edge, starting high, so it runs at half the underflow rate. Once the enable has been 0 across a clock edge, `ser_clk` is 1 and stays 1 until it is enabled again.
- R9: Every underflow sets the interrupt flag regardless of enables. Writing 1 to bit 1 of address 3 clears the flag, and a simultaneous underflow wins. `irq` is high exactly when the flag and the enable (bit 0 of address 3) are both 1.
- R10: Bits 6:4 of address 3 hold a priority level of 0 to 7 that reads back and appears on `irq_level`.
- R11: `bus_rdata` is registered. It shows the register selected by `bus_addr` one cycle later, with the values those registers held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable, one cycle per count step |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 1 | Underflow pulse for an external pin, 0 when disabled |
| ser_clk | output | 1 | Underflow divided by two for a serial port, 1 when disabled |
| irq | output | 1 | Interrupt request, flag gated by enable |
| irq_level | output | 3 | Programmed interrupt priority level |

## Verification
A wrong count shows at once on the count register read back through the port. It also shows in the timing of the underflow: `pin_out`, the edge on `ser_clk` and `irq` all appear one tick early or late. A misplaced reload shows as a wrong period between pulses from the very next underflow onward. A divider flop that is not forced high leaves `ser_clk` low, or inverts its phase, and this is visible one cycle after the output is disabled or re-enabled. A lost or sticky interrupt flag appears on `irq` in the cycle after the underflow or clear that should have moved it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_INTR   = 2'd3
  } reg_sel_e;

  localparam int CTL_RUN    = 0;
  localparam int CTL_PRESET = 1;
  localparam int CTL_OUTEN  = 2;

  localparam int INT_EN     = 0;
  localparam int INT_FLAG   = 1;
  localparam int INT_LVL_LO = 4;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          preset,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] count,
  output logic          uf
);
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic step;
  assign step = tick & run & ~preset;
  assign uf   = step & (count == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= ZERO;
    end else if (preset) begin
      count <= reload;
    end else if (step) begin
      if (count == ZERO) count <= reload;
      else               count <= count - ONE;
    end
  end
endmodule

// File: rtl/tmr_clkout.sv
module tmr_clkout (
  input  logic clk,
  input  logic rst,
  input  logic out_en,
  input  logic uf,
  output logic pin_out,
  output logic ser_clk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      ser_clk <= 1'b1;
    end else begin
      pin_out <= out_en & uf;
      if (!out_en)  ser_clk <= 1'b1;
      else if (uf)  ser_clk <= ~ser_clk;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    count,
  input  logic             uf,
  output logic [DW-1:0]    rdata,
  output logic             run,
  output logic             out_en,
  output logic             preset,
  output logic [DW-1:0]    reload,
  output logic             int_en,
  output logic             int_flag,
  output logic [LVL_W-1:0] level
);
  reg_sel_e sel;
  logic     wr_ctl, wr_rel, wr_int;
  logic [DW-1:0] rd_mux;

  assign sel    = reg_sel_e'(addr);
  assign wr_ctl = wr && (sel == SEL_CTRL);
  assign wr_rel = wr && (sel == SEL_RELOAD);
  assign wr_int = wr && (sel == SEL_INTR);
  assign preset = wr_ctl && wdata[CTL_PRESET];

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      out_en <= 1'b0;
      reload <= '0;
      int_en <= 1'b0;
      level  <= '0;
    end else begin
      if (wr_ctl) begin
        run    <= wdata[CTL_RUN];
        out_en <= wdata[CTL_OUTEN];
      end
      if (wr_rel) reload <= wdata;
      if (wr_int) begin
        int_en <= wdata[INT_EN];
        level  <= wdata[INT_LVL_LO +: LVL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             int_flag <= 1'b0;
    else if (uf)                         int_flag <= 1'b1;
    else if (wr_int && wdata[INT_FLAG])  int_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_mux[CTL_RUN]   = run;
        rd_mux[CTL_OUTEN] = out_en;
      end
      SEL_RELOAD: rd_mux = reload;
      SEL_COUNT:  rd_mux = count;
      SEL_INTR: begin
        rd_mux[INT_EN]                = int_en;
        rd_mux[INT_FLAG]              = int_flag;
        rd_mux[INT_LVL_LO +: LVL_W]   = level;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             pin_out,
  output logic             ser_clk,
  output logic             irq,
  output logic [LVL_W-1:0] irq_level
);
  logic          run, out_en, preset, int_en, int_flag, uf;
  logic [DW-1:0] reload, count;

  tmr_regs #(.DW(DW), .AW(AW), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .uf(uf), .rdata(bus_rdata), .run(run), .out_en(out_en),
    .preset(preset), .reload(reload), .int_en(int_en), .int_flag(int_flag),
    .level(irq_level)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .preset(preset),
    .reload(reload), .count(count), .uf(uf)
  );

  tmr_clkout u_out (
    .clk(clk), .rst(rst), .out_en(out_en), .uf(uf),
    .pin_out(pin_out), .ser_clk(ser_clk)
  );

  assign irq = int_flag & int_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          run,
  input logic          preset,
  input logic          out_en,
  input logic          uf,
  input logic          int_flag,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic          pin_out,
  input logic          ser_clk
);
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !preset && count != '0) |=> count == $past(count) - DW'(1));

  a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!(run && tick) && !preset) |=> $stable(count));

  a_r5_reload_on_uf: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !preset && count == '0) |=> count == $past(reload));

  a_r6_preset_load: assert property (@(posedge clk) disable iff (rst)
    preset |=> count == $past(reload));

  a_r7_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pin_out);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> ser_clk);

  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    (out_en && uf) |=> ser_clk != $past(ser_clk));

  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    uf |=> int_flag);
endmodule

bind tick_timer tmr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run), .preset(preset),
  .out_en(out_en), .uf(uf), .int_flag(int_flag), .count(count),
  .reload(reload), .pin_out(pin_out), .ser_clk(ser_clk)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pin_out, ser_clk, irq;
  logic [2:0] irq_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // requirement-level model state
  logic [7:0] m_cnt = 8'd0, m_rel = 8'd0;
  logic       m_run = 1'b0, m_oe = 1'b0, m_ser = 1'b1, m_flag = 1'b0, m_ie = 1'b0;
  logic [2:0] m_lvl = 3'd0;

  tick_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .ser_clk(ser_clk), .irq(irq), .irq_level(irq_level)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0:    return {5'b0, m_oe, 1'b0, m_run};
      2'd1:    return m_rel;
      2'd2:    return m_cnt;
      default: return {1'b0, m_lvl, 2'b0, m_flag, m_ie};
    endcase
  endfunction

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d, input bit t);
    logic [7:0] exp_rd;
    bit pre, uf, exp_pin;
    bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
    exp_rd  = rd_model(a);
    pre     = w && a == 2'd0 && d[1];
    uf      = t && m_run && !pre && m_cnt == 8'd0;
    exp_pin = m_oe && uf;
    if (pre)               m_cnt = m_rel;
    else if (t && m_run)   m_cnt = (m_cnt == 8'd0) ? m_rel : m_cnt - 8'd1;
    if (!m_oe)             m_ser = 1'b1;
    else if (uf)           m_ser = ~m_ser;
    if (uf)                              m_flag = 1'b1;
    else if (w && a == 2'd3 && d[1])     m_flag = 1'b0;
    if (w && a == 2'd0) begin m_run = d[0]; m_oe = d[2]; end
    if (w && a == 2'd1) m_rel = d;
    if (w && a == 2'd3) begin m_ie = d[0]; m_lvl = d[6:4]; end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    chk(bus_rdata == exp_rd, "R11 rdata", bus_rdata, exp_rd);
    chk(pin_out == exp_pin, "R7 pin_out", pin_out, exp_pin);
    chk(ser_clk == m_ser, "R8 ser_clk", ser_clk, m_ser);
    chk(irq == (m_flag && m_ie), "R9 irq", irq, m_flag && m_ie);
    chk(irq_level == m_lvl, "R10 irq_level", irq_level, m_lvl);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    step(1'b0, a, 8'd0, 1'b0);
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(pin_out == 1'b0, "R1 pin_out", pin_out, 0);
    chk(ser_clk == 1'b1, "R1 ser_clk", ser_clk, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk(v == 8'h00, "R1 count", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R1 intr", v, 8'h00);

    // R2 / R6: reload 5, run + outen + preset
    step(1'b1, 2'd1, 8'h05, 1'b0);
    step(1'b1, 2'd0, 8'hFF, 1'b0);
    rd(2'd0, v); chk(v == 8'h05, "R2 ctrl readback", v, 8'h05);
    rd(2'd2, v); chk(v == 8'h05, "R6 preset count", v, 8'h05);

    // R3 count down, hold without tick, write to count ignored
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd2, 8'hAA, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b0);
    rd(2'd2, v); chk(v == 8'h03, "R3 count after two ticks", v, 8'h03);

    // R4 stop retains, resume from retained
    step(1'b1, 2'd0, 8'h04, 1'b0);
    repeat (3) step(1'b0, 2'd0, 8'h00, 1'b1);
    rd(2'd2, v); chk(v == 8'h03, "R4 frozen count", v, 8'h03);
    step(1'b1, 2'd0, 8'h05, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    rd(2'd2, v); chk(v == 8'h02, "R4 resumed count", v, 8'h02);

    // R5 / R7 / R8 / R9 underflow with output and interrupt enabled
    step(1'b1, 2'd3, 8'h01, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk(pin_out == 1'b1, "R7 pulse after underflow", pin_out, 1);
    chk(ser_clk == 1'b0, "R8 first toggle", ser_clk, 0);
    chk(irq == 1'b1, "R9 irq raised", irq, 1);
    rd(2'd2, v); chk(v == 8'h05, "R5 reloaded", v, 8'h05);
    chk(pin_out == 1'b0, "R7 pulse one cycle", pin_out, 0);

    // R9 clear, R10 level
    step(1'b1, 2'd3, 8'h03, 1'b0);
    chk(irq == 1'b0, "R9 cleared", irq, 0);
    step(1'b1, 2'd3, 8'h51, 1'b0);
    chk(irq_level == 3'd5, "R10 level out", irq_level, 5);
    rd(2'd3, v); chk(v == 8'h51, "R10 intr readback", v, 8'h51);

    // R8 disable -> idle high, R7 pin quiet on underflow
    step(1'b1, 2'd0, 8'h01, 1'b0);
    step(1'b0, 2'd0, 8'h00, 1'b0);
    chk(ser_clk == 1'b1, "R8 idle high", ser_clk, 1);
    repeat (6) step(1'b0, 2'd0, 8'h00, 1'b1);
    chk(pin_out == 1'b0, "R7 disabled pin", pin_out, 0);
    chk(irq == 1'b1, "R9 flag set again", irq, 1);

    // R6 preset beats tick while running; preset while stopped
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd0, 8'h03, 1'b1);
    rd(2'd2, v); chk(v == 8'h05, "R6 preset wins over tick", v, 8'h05);
    step(1'b0, 2'd0, 8'h00, 1'b1);
    step(1'b1, 2'd0, 8'h02, 1'b0);
    rd(2'd2, v); chk(v == 8'h05, "R6 preset while stopped", v, 8'h05);
    rd(2'd0, v); chk(v == 8'h00, "R2 preset bit reads 0", v, 8'h00);

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      bit w;
      w = ($urandom % 4) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      if (a == 2'd1) d = 8'($urandom % 12);
      if (a == 2'd0) d = {5'b0, 1'($urandom % 3 != 0), 1'($urandom % 8 == 0), 1'($urandom % 5 != 0)};
      step(w, a, d, 1'($urandom % 2));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule